// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block brings a processor up from power-on. Once the power-good input goes high, it divides the system clock down into a slow mode clock for an external serial mode memory. It then captures one configuration bit per mode-clock period, until the whole configuration word has been shifted in. The processor is held in reset for the entire load, and reset is released on the system clock edge that stores the final bit.

After loading, the block holds the full configuration vector and decodes three things from it:

- the effective byte order, which combines a board pin with one configuration bit;
- a four-level output data rate;
- a check that three mandatory configuration bits are set.

If power-good falls at any point, all progress is discarded. A fresh load starts from bit 0 on the next rising edge of power-good.

Top module: `boot_mode_loader`

## Requirements
- R1: While power-good is low, the mode clock is low, the configuration vector is all zeros, the done flag is low and the processor reset output is high.
- R2: The mode clock has a period of 256 system clock cycles. It is high for 128 cycles and then low for 128 cycles. The first high half begins in the cycle that follows the first rising system clock edge at which power-good is sampled high.
- R3: Each bit is sampled on the system clock edge that ends the fifth system cycle of its mode-clock period, counting the cycle in which the mode clock rises as the first. The data input only has to be valid from the rise of the mode clock up to that edge, and any value outside that window has no effect.
- R4: The stream is 256 bits long and arrives least significant bit first. Bit k of the stream, counting from 0, is stored in vector bit k and is visible on the vector output from the edge that samples it.
- R5: The done flag rises, and the processor reset output falls, on the same system clock edge that captures bit 255. Both then hold their values for as long as power-good stays high.
- R6: Once done is set, the mode clock stays low and the vector no longer changes while power-good stays high.
- R7: The big-endian output is the OR of the endianness pin and vector bit 8. Either source alone makes the output 1.
- R8: The rate output is decoded from vector bits 14:13 as follows:
  - 10 gives 0 (full rate);
  - 11 gives 1 (83 percent);
  - 00 gives 2 (67 percent);
  - 01 gives 3 (50 percent).
- R9: The illegal-configuration flag is 1 exactly when done is set and any of vector bits 20, 33 or 37 is 0.
- R10: If power-good falls during a load, the bit position, phase and vector are cleared on the next edge. The next load then restarts from bit 0 with a new mode-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| pwr_ok_i | input | 1 | Power-good; low clears the block synchronously |
| mode_din_i | input | 1 | Serial configuration data from the mode memory |
| endian_pin_i | input | 1 | Board strap that requests big-endian mode |
| mode_clk_o | output | 1 | Divided clock sent to the mode memory |
| mode_vec_o | output | 256 | Captured configuration vector |
| big_endian_o | output | 1 | Effective byte order (1 = big-endian) |
| out_rate_o | output | 2 | Decoded output data rate, 0 fastest to 3 slowest |
| cfg_done_o | output | 1 | Load complete |
| cfg_illegal_o | output | 1 | A mandatory configuration bit is 0 |
| cpu_rst_o | output | 1 | Processor reset, active high |

## Verification
Three events coincide on one system clock edge: the capture of the last bit, the stopping of the mode clock, and the release of reset. The mode clock is still high on that edge, because the sample point falls in its high half. The bench runs two complete loads against a per-cycle model and compares the mode clock, done and reset in every cycle, so any cycle of skew between these events is flagged. A second coincidence is a power-good drop in the middle of a period. This is provoked partway through a load, and the vector and mode clock are then expected to be cleared at once and to restart from bit 0. Throughout every load, the bench drives the inverted data bit outside the valid window, so a wrong sample phase shows up in the captured vector.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
    localparam int ENDIAN_BIT = 8;
    localparam int RATE_LO    = 13;
    localparam int REQ_A      = 20;
    localparam int REQ_B      = 33;
    localparam int REQ_C      = 37;

    typedef enum logic [1:0] {
        RATE_FULL = 2'd0,
        RATE_83   = 2'd1,
        RATE_67   = 2'd2,
        RATE_50   = 2'd3
    } out_rate_e;
endpackage

// File: rtl/bm_clkgen.sv
module bm_clkgen #(
    parameter int DIV       = 256,
    parameter int SAMPLE_PH = 4
) (
    input  logic clk_i,
    input  logic pwr_ok_i,
    input  logic done_i,
    input  logic stop_i,
    output logic mode_clk_o,
    output logic sample_o
);
    localparam int PW = $clog2(DIV);

    typedef struct packed {
        logic          run;
        logic [PW-1:0] ph;
    } clk_st_t;

    clk_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!pwr_ok_i) begin
            s_d = '0;
        end else if (!s_q.run) begin
            if (!done_i) begin
                s_d.run = 1'b1;
                s_d.ph  = '0;
            end
        end else if (stop_i) begin
            s_d.run = 1'b0;
            s_d.ph  = '0;
        end else begin
            s_d.ph = (s_q.ph == PW'(DIV - 1)) ? '0 : s_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign mode_clk_o = s_q.run && (s_q.ph < PW'(DIV / 2));
    assign sample_o   = s_q.run && (s_q.ph == PW'(SAMPLE_PH));

    // R2: the mode clock changes level only at a half-period boundary
    a_r2_clk_steady: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        (s_q.run && !stop_i && s_q.ph != PW'(DIV / 2 - 1) && s_q.ph != PW'(DIV - 1))
        |=> $stable(mode_clk_o));

    // R2: every rising edge of the mode clock starts a new period at phase zero
    a_r2_rise_phase: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        $rose(mode_clk_o) |-> (s_q.ph == '0));
endmodule

// File: rtl/bm_shifter.sv
module bm_shifter #(
    parameter int NBITS = 256
) (
    input  logic             clk_i,
    input  logic             pwr_ok_i,
    input  logic             sample_i,
    input  logic             data_i,
    output logic [NBITS-1:0] vec_o,
    output logic             done_o,
    output logic             last_o
);
    localparam int CW = $clog2(NBITS);

    typedef struct packed {
        logic             done;
        logic [CW-1:0]    cnt;
        logic [NBITS-1:0] vec;
    } sh_st_t;

    sh_st_t s_d, s_q;

    assign last_o = sample_i && !s_q.done && (s_q.cnt == CW'(NBITS - 1));

    always_comb begin
        s_d = s_q;
        if (!pwr_ok_i) begin
            s_d = '0;
        end else if (sample_i && !s_q.done) begin
            s_d.vec[s_q.cnt] = data_i;
            if (last_o) begin
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign vec_o  = s_q.vec;
    assign done_o = s_q.done;

    // R5/R6: done is sticky and freezes the vector while power is good
    a_r6_frozen: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        s_q.done |=> (s_q.done && $stable(s_q.vec)));

    // R4: a sample strobe never falls on a completed load
    a_r4_no_sample_after_done: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        s_q.done |-> !sample_i);
endmodule

// File: rtl/bm_decode.sv
module bm_decode
    import boot_mode_pkg::*;
#(
    parameter int NBITS = 256
) (
    input  logic [NBITS-1:0] vec_i,
    input  logic             pin_i,
    input  logic             done_i,
    output logic             big_endian_o,
    output out_rate_e        rate_o,
    output logic             illegal_o
);
    always_comb begin
        big_endian_o = pin_i | vec_i[ENDIAN_BIT];
        unique case (vec_i[RATE_LO+1:RATE_LO])
            2'b10:   rate_o = RATE_FULL;
            2'b11:   rate_o = RATE_83;
            2'b00:   rate_o = RATE_67;
            default: rate_o = RATE_50;
        endcase
        illegal_o = done_i & ~(vec_i[REQ_A] & vec_i[REQ_B] & vec_i[REQ_C]);
    end
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
    import boot_mode_pkg::*;
#(
    parameter int NBITS     = 256,
    parameter int DIV       = 256,
    parameter int SAMPLE_PH = 4
) (
    input  logic             clk_i,
    input  logic             pwr_ok_i,
    input  logic             mode_din_i,
    input  logic             endian_pin_i,
    output logic             mode_clk_o,
    output logic [NBITS-1:0] mode_vec_o,
    output logic             big_endian_o,
    output logic [1:0]       out_rate_o,
    output logic             cfg_done_o,
    output logic             cfg_illegal_o,
    output logic             cpu_rst_o
);
    logic      sample;
    logic      last;
    logic      done;
    out_rate_e rate;

    bm_clkgen #(.DIV(DIV), .SAMPLE_PH(SAMPLE_PH)) u_clk (
        .clk_i      (clk_i),
        .pwr_ok_i   (pwr_ok_i),
        .done_i     (done),
        .stop_i     (last),
        .mode_clk_o (mode_clk_o),
        .sample_o   (sample)
    );

    bm_shifter #(.NBITS(NBITS)) u_shift (
        .clk_i    (clk_i),
        .pwr_ok_i (pwr_ok_i),
        .sample_i (sample),
        .data_i   (mode_din_i),
        .vec_o    (mode_vec_o),
        .done_o   (done),
        .last_o   (last)
    );

    bm_decode #(.NBITS(NBITS)) u_dec (
        .vec_i        (mode_vec_o),
        .pin_i        (endian_pin_i),
        .done_i       (done),
        .big_endian_o (big_endian_o),
        .rate_o       (rate),
        .illegal_o    (cfg_illegal_o)
    );

    assign out_rate_o = rate;
    assign cfg_done_o = done;
    assign cpu_rst_o  = ~done;

    // R7: the strap alone selects big-endian
    a_r7_pin_wins: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        endian_pin_i |-> big_endian_o);

    // R9: the illegal flag only appears on a finished load
    a_r9_only_done: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        cfg_illegal_o |-> cfg_done_o);

    // R6: the mode clock is quiet after completion
    a_r6_clk_quiet: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        cfg_done_o |-> !mode_clk_o);

    // R5: reset release coincides with completion, caused by the final sample
    a_r5_release: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        $rose(cfg_done_o) |-> ($fell(cpu_rst_o) && $past(sample)));
endmodule

// File: tb/boot_mode_loader_test.sv
module boot_mode_loader_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         pg  = 1'b0;
    logic         md  = 1'b0;
    logic         pin = 1'b0;
    logic         mclk, be, done, ill, rst;
    logic [255:0] vec;
    logic [1:0]   rate;

    boot_mode_loader uut (
        .clk_i         (clk),
        .pwr_ok_i      (pg),
        .mode_din_i    (md),
        .endian_pin_i  (pin),
        .mode_clk_o    (mclk),
        .mode_vec_o    (vec),
        .big_endian_o  (be),
        .out_rate_o    (rate),
        .cfg_done_o    (done),
        .cfg_illegal_o (ill),
        .cpu_rst_o     (rst)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string ctx = "R1";

    bit           m_load = 0;
    bit           m_done = 0;
    int           m_n = 0;
    logic [255:0] m_vec = '0;
    logic [255:0] cur_pat = '0;
    logic [255:0] pat_a, pat_b;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%s) cycle %0d actual=%0h expected=%0h", tag, ctx, cycles, act, exp);
        end
    endtask

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        cycles++;
        if (!pg) begin
            m_load = 0; m_done = 0; m_n = 0; m_vec = '0;
        end else if (!m_load && !m_done) begin
            m_load = 1; m_n = 0;
        end else if (m_load) begin
            if (m_n % 256 == 4) begin
                m_vec[m_n / 256] = md;
                if (m_n / 256 == 255) begin
                    m_load = 0;
                    m_done = 1;
                end
            end
            m_n++;
        end
    end

    always @(negedge clk) begin
        logic [1:0] e_rate;
        logic       e_ill;
        case (m_vec[14:13])
            2'b10:   e_rate = 2'd0;
            2'b11:   e_rate = 2'd1;
            2'b00:   e_rate = 2'd2;
            default: e_rate = 2'd3;
        endcase
        e_ill = m_done & ~(m_vec[20] & m_vec[33] & m_vec[37]);
        chk(mclk === (m_load && (m_n % 256) < 128), "R2/R6 mode clock", 256'(mclk),
            256'(m_load && (m_n % 256) < 128));
        chk(vec === m_vec, "R3/R4 vector", vec, m_vec);
        chk(done === m_done, "R5 done", 256'(done), 256'(m_done));
        chk(rst === !m_done, "R5 cpu reset", 256'(rst), 256'(!m_done));
        chk(be === (pin | m_vec[8]), "R7 endian", 256'(be), 256'(pin | m_vec[8]));
        chk(rate === e_rate, "R8 rate", 256'(rate), 256'(e_rate));
        chk(ill === e_ill, "R9 illegal", 256'(ill), 256'(e_ill));
        if (m_load) begin
            int ph = m_n % 256;
            int b  = m_n / 256;
            md = (ph <= 4) ? cur_pat[b] : ~cur_pat[b];
        end else begin
            md = ~md;
        end
    end

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 190000) begin
            n_bad++;
            $display("FAIL R5 watchdog expired: actual done=%0b expected done=1", done);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            pat_a[i] = ((i * 37 + 11) % 7) < 3;
            pat_b[i] = ((i * 13 + 5) % 5) < 2;
        end
        // pattern A: little-endian bit clear, rate code 10, mandatory bits set
        pat_a[8] = 0; pat_a[14] = 1; pat_a[13] = 0;
        pat_a[20] = 1; pat_a[33] = 1; pat_a[37] = 1;
        // pattern B: big-endian bit set, rate code 01, bit 33 cleared
        pat_b[8] = 1; pat_b[14] = 0; pat_b[13] = 1;
        pat_b[20] = 1; pat_b[33] = 0; pat_b[37] = 1;

        ctx = "R1 before power-good";
        repeat (12) @(posedge clk);
        #1 pg = 1; cur_pat = pat_a; ctx = "R2 first load";
        while (!m_done) @(posedge clk);
        #1 pin = 1; ctx = "R6 after done, pin high";
        repeat (30) @(posedge clk);
        #1 pg = 0; ctx = "R10 power dropped";
        repeat (5) @(posedge clk);
        #1 pg = 1; cur_pat = ~pat_a; ctx = "R10 partial load";
        repeat (3 * 256 + 50) @(posedge clk);
        #1 pg = 0; ctx = "R10 drop mid-period";
        repeat (4) @(posedge clk);
        #1 pin = 0; pg = 1; cur_pat = pat_b; ctx = "R10 restarted load";
        while (!m_done) @(posedge clk);
        ctx = "R9 illegal config held";
        repeat (20) @(posedge clk);
        #1;
        finish_run();
    end
endmodule